// File: doc/BRIEF.md
# Draw-State Group Register Bank

This block is a bank of control registers that keeps context for up to 32 draw-state groups. Each group holds a 16-bit dword count, a 3-bit mode mask, a 64-bit base address and a saved stream pointer. The stream pointer is a 64-bit stream base plus a 32-bit stream length. All access goes through one synchronous register port: a 4-bit word address, a write enable and a 32-bit write word. The 32-bit read word is a combinational function of the address and the stored state, so a read has no effect on anything.

A group is programmed through a single load address as a three-word burst. The first word is a header naming the group, its count and its mode mask. The second word is the low half of the group's base address and the third is the high half. After the third word the sequence starts again at a header. A write to the pick address makes a group current. The shared head and base readback registers then show that group's stored values. The live stream registers are saved into the previously picked group, and the newly picked group's saved stream values are restored into them.

Address map, as word addresses:

| Addr | Name | Write | Read |
|------|------|-------|------|
| 0 | LOAD | three-phase sequence | last word written here |
| 1 | PICK | select a group, index in bits 4:0 | current selection |
| 2 | LIVE | write-1-to-clear | active-group mask |
| 3 | HEAD | ignored | count in 15:0, mode in 22:20 |
| 4 / 5 | BASE_LO / BASE_HI | ignored | base of the picked group |
| 6 / 7 | STRM_LO / STRM_HI | direct write | live stream base |
| 8 | STRM_LEN | direct write | live stream length |
| 9 to 15 | none | ignored | zero |

Top module: `gsb_top`

## Requirements
- R1: A synchronous reset clears the following: the load phase, the LIVE mask, the selection, the previous-pick pointer, every readback and stream register, the last LOAD word, and all per-group storage. Every address then reads zero.
- R2: Writes to LOAD step a phase counter 0, 1, 2 and then back to 0. Writes to other addresses and reads do not move the phase.
- R3: A phase-0 LOAD write is a header with the group index in bits 28:24, the count in bits 15:0 and the mode mask in bits 22:20. The count and mode are stored in that group, and all other header bits are ignored.
- R4: A phase-0 LOAD write sets the indexed bit of LIVE and makes that index the current selection, which reads back from PICK in bits 4:0. It does not change HEAD or BASE readback.
- R5: Phase-1 and phase-2 LOAD writes store the low and high 32 bits of the base address into the group that is selected at the time of each write. This holds even if a PICK write came between them.
- R6: A PICK write loads HEAD with the picked group's count in bits 15:0 and mode in bits 22:20, with all other bits zero. It loads BASE_LO and BASE_HI with that group's base. HEAD and BASE change at no other time.
- R7: A PICK write saves STRM_LO, STRM_HI and STRM_LEN into the previously picked group. It loads them from the newly picked group's saved values and records the new index as the previous pick.
- R8: A PICK of the index that was picked last leaves STRM_LO, STRM_HI and STRM_LEN unchanged, because the save happens before the restore.
- R9: STRM_LO, STRM_HI and STRM_LEN take direct writes. A LIVE write clears the mask bits set in the write word. Writes to HEAD, BASE_LO, BASE_HI and unmapped addresses have no effect.
- R10: A LOAD read returns the last word written to LOAD, and reads at any address have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Word address of the access |
| we | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word for `addr`, combinational |

## Verification
The assertions assume that `addr` and `wdata` are known whenever `we` is high. They also assume that a PICK index and a header index always fall inside the group count, which holds by width at the default of 32 groups. The stimulus changes inputs only on the falling edge and always drives fully known values. It interleaves PICK writes between LOAD phases so that R5 sees a selection change in the middle of a burst. It repeats a PICK of the same group to reach the save-then-restore order of R8. A long pseudo-random run mixes every address with reads and writes. The bench compares `rdata` every cycle against a behavioural model of the register map.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  parameter int NGRP     = 32;
  parameter int DW       = 32;
  parameter int CNT_W    = 16;
  parameter int MODE_W   = 3;
  parameter int IDX_LSB  = 24;
  parameter int MODE_LSB = 20;
  parameter int ADDR_W   = 4;
  localparam int IDX_W   = $clog2(NGRP);
  localparam int BW      = 2 * DW;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD    = 4'd0,
    A_PICK    = 4'd1,
    A_LIVE    = 4'd2,
    A_HEAD    = 4'd3,
    A_BASE_LO = 4'd4,
    A_BASE_HI = 4'd5,
    A_STRM_LO = 4'd6,
    A_STRM_HI = 4'd7,
    A_STRM_LN = 4'd8
  } gsb_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] mode;
    logic [BW-1:0]     base;
    logic [BW-1:0]     sbase;
    logic [DW-1:0]     slen;
  } grp_t;
endpackage

// File: rtl/gsb_phase_seq.sv
module gsb_phase_seq #(
  parameter int NPH  = 3,
  localparam int PH_W = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (step)
      phase <= (phase == PH_W'(NPH - 1)) ? '0 : phase + 1'b1;
  end

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> phase == (($past(phase) == PH_W'(NPH - 1)) ? '0 : $past(phase) + 1'b1));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase));
endmodule

// File: rtl/gsb_group_store.sv
module gsb_group_store
  import gsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_we,
  input  logic [IDX_W-1:0]  hdr_idx,
  input  logic [CNT_W-1:0]  hdr_cnt,
  input  logic [MODE_W-1:0] hdr_mode,
  input  logic              base_we,
  input  logic              base_hi,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DW-1:0]     base_data,
  input  logic              save_we,
  input  logic [IDX_W-1:0]  save_idx,
  input  logic [BW-1:0]     save_base,
  input  logic [DW-1:0]     save_len,
  input  logic [IDX_W-1:0]  rd_idx,
  output grp_t              rd_grp
);
  grp_t mem [NGRP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGRP; i++) mem[i] <= '0;
    end else begin
      if (hdr_we) begin
        mem[hdr_idx].cnt  <= hdr_cnt;
        mem[hdr_idx].mode <= hdr_mode;
      end
      if (base_we) begin
        if (base_hi) mem[base_idx].base[BW-1:DW] <= base_data;
        else         mem[base_idx].base[DW-1:0]  <= base_data;
      end
      if (save_we) begin
        mem[save_idx].sbase <= save_base;
        mem[save_idx].slen  <= save_len;
      end
    end
  end

  assign rd_grp = mem[rd_idx];

  // R5
  base_lo_store_chk: assert property (@(posedge clk) disable iff (rst)
    base_we && !base_hi |=> mem[$past(base_idx)].base[DW-1:0] == $past(base_data));

  // R3
  hdr_store_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_we |=> mem[$past(hdr_idx)].cnt == $past(hdr_cnt));
endmodule

// File: rtl/gsb_top.sv
module gsb_top
  import gsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [1:0]       phase;
  logic [NGRP-1:0]  live;
  logic [IDX_W-1:0] sel, prev;
  logic [DW-1:0]    head_rb, last_ld, strm_len;
  logic [BW-1:0]    base_rb, strm_base;
  grp_t             rd_grp;

  logic ld_wr, pk_wr, hdr_wr, base_wr;
  logic [IDX_W-1:0] hdr_idx, pk_idx;

  assign ld_wr   = we && (addr == A_LOAD);
  assign pk_wr   = we && (addr == A_PICK);
  assign hdr_wr  = ld_wr && (phase == 2'd0);
  assign base_wr = ld_wr && (phase != 2'd0);
  assign hdr_idx = wdata[IDX_LSB +: IDX_W];
  assign pk_idx  = wdata[IDX_W-1:0];

  gsb_phase_seq #(.NPH(3)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .step  (ld_wr),
    .phase (phase)
  );

  gsb_group_store u_store (
    .clk       (clk),
    .rst       (rst),
    .hdr_we    (hdr_wr),
    .hdr_idx   (hdr_idx),
    .hdr_cnt   (wdata[CNT_W-1:0]),
    .hdr_mode  (wdata[MODE_LSB +: MODE_W]),
    .base_we   (base_wr),
    .base_hi   (phase == 2'd2),
    .base_idx  (sel),
    .base_data (wdata),
    .save_we   (pk_wr),
    .save_idx  (prev),
    .save_base (strm_base),
    .save_len  (strm_len),
    .rd_idx    (pk_idx),
    .rd_grp    (rd_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= '0;
      sel       <= '0;
      prev      <= '0;
      head_rb   <= '0;
      base_rb   <= '0;
      strm_base <= '0;
      strm_len  <= '0;
      last_ld   <= '0;
    end else begin
      if (ld_wr) last_ld <= wdata;
      if (hdr_wr) begin
        live[hdr_idx] <= 1'b1;
        sel           <= hdr_idx;
      end
      if (pk_wr) begin
        sel     <= pk_idx;
        prev    <= pk_idx;
        head_rb <= DW'(rd_grp.cnt) | (DW'(rd_grp.mode) << MODE_LSB);
        base_rb <= rd_grp.base;
        // same group: save-then-restore returns the live values unchanged
        if (pk_idx != prev) begin
          strm_base <= rd_grp.sbase;
          strm_len  <= rd_grp.slen;
        end
      end
      if (we && addr == A_LIVE)    live <= live & ~wdata[NGRP-1:0];
      if (we && addr == A_STRM_LO) strm_base[DW-1:0]  <= wdata;
      if (we && addr == A_STRM_HI) strm_base[BW-1:DW] <= wdata;
      if (we && addr == A_STRM_LN) strm_len <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_LOAD:    rdata = last_ld;
      A_PICK:    rdata = DW'(sel);
      A_LIVE:    rdata = DW'(live);
      A_HEAD:    rdata = head_rb;
      A_BASE_LO: rdata = base_rb[DW-1:0];
      A_BASE_HI: rdata = base_rb[BW-1:DW];
      A_STRM_LO: rdata = strm_base[DW-1:0];
      A_STRM_HI: rdata = strm_base[BW-1:DW];
      A_STRM_LN: rdata = strm_len;
      default:   rdata = '0;
    endcase
  end

  // R4
  live_set_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_wr |=> live[$past(hdr_idx)] && sel == $past(hdr_idx));

  // R7
  prev_track_chk: assert property (@(posedge clk) disable iff (rst)
    pk_wr |=> prev == $past(pk_idx) && sel == $past(pk_idx));

  // R8
  same_pick_chk: assert property (@(posedge clk) disable iff (rst)
    pk_wr && pk_idx == prev |=> $stable(strm_base) && $stable(strm_len));

  // R6
  rb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pk_wr |=> $stable(head_rb) && $stable(base_rb));
endmodule

// File: tb/test_gsb_top.sv
`timescale 1ns/1ps
module test_gsb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;

  always #2 clk = ~clk;

  gsb_top i_gsb_top (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .we    (we),
    .wdata (wdata),
    .rdata (rdata)
  );

  int vecs = 0;
  int errs = 0;

  // behavioural model of the register map
  logic [15:0] m_cnt  [32];
  logic [2:0]  m_mode [32];
  logic [63:0] m_base [32];
  logic [63:0] m_sb   [32];
  logic [31:0] m_sl   [32];
  int          m_phase;
  logic [31:0] m_live, m_head, m_last, m_slen;
  logic [4:0]  m_sel, m_prev;
  logic [63:0] m_rbase, m_sbase;

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_cnt[i] = '0; m_mode[i] = '0; m_base[i] = '0; m_sb[i] = '0; m_sl[i] = '0;
    end
    m_phase = 0; m_live = '0; m_head = '0; m_last = '0; m_slen = '0;
    m_sel = '0; m_prev = '0; m_rbase = '0; m_sbase = '0;
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0: return m_last;
      4'd1: return {27'd0, m_sel};
      4'd2: return m_live;
      4'd3: return m_head;
      4'd4: return m_rbase[31:0];
      4'd5: return m_rbase[63:32];
      4'd6: return m_sbase[31:0];
      4'd7: return m_sbase[63:32];
      4'd8: return m_slen;
      default: return '0;
    endcase
  endfunction

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    logic [4:0] k;
    case (a)
      4'd0: begin
        m_last = d;
        if (m_phase == 0) begin
          k = d[28:24];
          m_cnt[k] = d[15:0];
          m_mode[k] = d[22:20];
          m_live[k] = 1'b1;
          m_sel = k;
        end else if (m_phase == 1) m_base[m_sel][31:0] = d;
        else m_base[m_sel][63:32] = d;
        m_phase = (m_phase + 1) % 3;
      end
      4'd1: begin
        k = d[4:0];
        m_sb[m_prev] = m_sbase;
        m_sl[m_prev] = m_slen;
        m_sbase = m_sb[k];
        m_slen = m_sl[k];
        m_head = {9'd0, m_mode[k], 4'd0, m_cnt[k]};
        m_rbase = m_base[k];
        m_sel = k;
        m_prev = k;
      end
      4'd2: m_live = m_live & ~d;
      4'd6: m_sbase[31:0] = d;
      4'd7: m_sbase[63:32] = d;
      4'd8: m_slen = d;
      default: ;
    endcase
  endtask

  task automatic step(string tag, logic [3:0] a, logic w, logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    e = exp_read(a);
    vecs++;
    if (rdata !== e) begin
      errs++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, e);
    end
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic rd_all(string tag);
    for (int a = 0; a < 11; a++) step(tag, 4'(a), 1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic logic [31:0] hdr(logic [4:0] idx, logic [15:0] cnt, logic [2:0] mode);
    return {3'b101, idx, 1'b1, mode, 4'hA, cnt};
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();
    rd_all("R1 reset state");

    // R3 R4 R5: program group 5
    step("R3 header", 4'd0, 1'b1, hdr(5'd5, 16'h1234, 3'd5));
    step("R4 pick after header", 4'd1, 1'b0, 0);
    step("R4 head unchanged", 4'd3, 1'b0, 0);
    step("R5 base lo", 4'd0, 1'b1, 32'hA5A5_0001);
    step("R10 load readback", 4'd0, 1'b0, 0);
    step("R5 base hi", 4'd0, 1'b1, 32'h0BAD_F00D);
    step("R4 live", 4'd2, 1'b0, 0);
    step("R6 pick 5", 4'd1, 1'b1, 32'hFFFF_FFE5);
    step("R6 head", 4'd3, 1'b0, 0);
    step("R6 base lo", 4'd4, 1'b0, 0);
    step("R6 base hi", 4'd5, 1'b0, 0);

    // R7: stream context swap
    step("R9 strm lo", 4'd6, 1'b1, 32'h1111_2222);
    step("R9 strm hi", 4'd7, 1'b1, 32'h3333_4444);
    step("R9 strm len", 4'd8, 1'b1, 32'h0000_0080);
    step("R3 header g9", 4'd0, 1'b1, hdr(5'd9, 16'hBEEF, 3'd2));
    step("R5 g9 lo", 4'd0, 1'b1, 32'h9000_0000);
    step("R5 g9 hi", 4'd0, 1'b1, 32'h0000_0009);
    step("R7 pick 9", 4'd1, 1'b1, 32'd9);
    rd_all("R7 after pick 9");
    step("R9 strm lo g9", 4'd6, 1'b1, 32'h9999_0000);
    step("R7 pick 5 back", 4'd1, 1'b1, 32'd5);
    rd_all("R7 restore 5");

    // R8: same index twice
    step("R9 strm len edit", 4'd8, 1'b1, 32'h0000_0777);
    step("R8 pick 5 again", 4'd1, 1'b1, 32'd5);
    rd_all("R8 same pick");
    step("R7 pick 9 again", 4'd1, 1'b1, 32'd9);
    rd_all("R7 g9 saved");

    // R9: ignored writes and clear
    step("R9 head write", 4'd3, 1'b1, 32'hFFFF_FFFF);
    step("R9 base lo write", 4'd4, 1'b1, 32'hFFFF_FFFF);
    step("R9 base hi write", 4'd5, 1'b1, 32'hFFFF_FFFF);
    step("R9 unmapped write", 4'd12, 1'b1, 32'hFFFF_FFFF);
    rd_all("R9 ignored writes");
    step("R9 live clear", 4'd2, 1'b1, 32'h0000_0020);
    step("R9 live after clear", 4'd2, 1'b0, 0);

    // R5: pick between phases
    step("R3 header g3", 4'd0, 1'b1, hdr(5'd3, 16'h0042, 3'd7));
    step("R5 pick 7 mid burst", 4'd1, 1'b1, 32'd7);
    step("R5 lo to g7", 4'd0, 1'b1, 32'h7777_0000);
    step("R2 other write no phase", 4'd6, 1'b1, 32'h5);
    step("R5 hi to g7", 4'd0, 1'b1, 32'h0000_7777);
    step("R2 phase wrapped", 4'd0, 1'b1, hdr(5'd31, 16'hFFFF, 3'd1));
    step("R6 pick 7", 4'd1, 1'b1, 32'd7);
    rd_all("R5 g7 base");
    step("R6 pick 3", 4'd1, 1'b1, 32'd3);
    rd_all("R5 g3 no base");

    // mixed pseudo-random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 10));
      step("R2/R3/R5/R7/R9 mix", a, 1'($urandom_range(0, 1)), $urandom);
    end

    do_reset();
    rd_all("R1 second reset");
    step("R1 group cleared", 4'd1, 1'b1, 32'd9);
    rd_all("R1 group cleared");
    finish_run();
  end
endmodule